// File: doc/BRIEF.md
# Split-Mode Display Prefetch FIFO

This block holds words fetched from memory by a DMA engine until a display pixel pipeline consumes them. A single storage array of `DEPTH` words (512 by default) serves as one FIFO when the display is driven as a single panel. When the display is driven as two halves, the same array is cut into two independent FIFOs of `DEPTH/2` words each.

Each active FIFO compares its word count against a programmable fill threshold. While the count is below that threshold, the FIFO asks the DMA engine for more data. Software normally sets the threshold to the effective FIFO size minus (2 × burst length + 3) words. This leaves enough room that a burst already in flight can never overrun the FIFO.

The DMA engine writes through one port and steers each word with a half-select bit. Each half has its own read strobe and its own registered read data. The mode and the threshold are captured only while the block is idle, and a mode change flushes both FIFOs.

Top module: `splitfifo`

## Requirements
- R1: In single mode (mode input 0), FIFO 0 holds `DEPTH` words and delivers them in write order, and `full[0]` rises at exactly `DEPTH` words. Every write goes to FIFO 0 whatever the half-select is. FIFO 1 is inactive: its count stays 0, its read strobe has no effect and sets no flag, and bit 1 of the request, full and underflow outputs stays 0.
- R2: In dual mode (mode input 1), the write half-select picks FIFO 0 (value 0) or FIFO 1 (value 1). Each FIFO holds `DEPTH/2` words, delivers them in its own write order, and raises its `full` bit at exactly `DEPTH/2` words without affecting the other FIFO.
- R3: For an active FIFO i, `dmaReq[i]` is 1 exactly while its count is strictly below the captured threshold. An inactive FIFO never requests.
- R4: The mode and threshold inputs are captured on a clock edge only when both counts are zero and no write or read strobe is asserted in that cycle. Changes at any other time have no effect until such an edge. A capture that changes the mode resets both FIFOs' pointers.
- R5: A write to a full FIFO is dropped and leaves its count unchanged. It sets that FIFO's `overflow` bit, which then stays 1 until reset.
- R6: A read strobe on an active, empty FIFO leaves its read data at the previous value. It sets that FIFO's `underflow` bit, which then stays 1 until reset.
- R7: A write and a read to the same FIFO in one cycle, when it is neither empty nor full, both take effect and leave the count unchanged.
- R8: Read data is registered: the word taken by a read strobe sampled at one clock edge is on the read data output from that edge on, and it holds until the next accepted read of that FIFO.
- R9: During reset, and right after it, both counts are 0, `empty` is 2'b11, `full`, `overflow`, `underflow` and `dmaReq` are 0, and both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDual | input | 1 | Mode request: 0 single FIFO, 1 two half FIFOs |
| cfgThresh | input | CW | Fill threshold request in words |
| wrEn | input | 1 | DMA write strobe |
| wrSel | input | 1 | Target half of the write (dual mode only) |
| wrData | input | W | DMA write word |
| rdEn | input | 2 | Read strobe per FIFO |
| rdData0 | output | W | Registered read word of FIFO 0 |
| rdData1 | output | W | Registered read word of FIFO 1 |
| count0 | output | CW | Word count of FIFO 0 |
| count1 | output | CW | Word count of FIFO 1 |
| full | output | 2 | Full flag per FIFO |
| empty | output | 2 | Empty flag per FIFO |
| dmaReq | output | 2 | DMA request per FIFO |
| overflow | output | 2 | Sticky dropped-write flag per FIFO |
| underflow | output | 2 | Sticky empty-read flag per FIFO |

## Verification
A DMA write and a pixel-side read can land on the same FIFO in the same cycle, and the two pointer moves must then cancel in the count. The vector table provokes this on a partly filled FIFO in dual mode. It also provokes it across halves, where one half is written while the other is read. Each vector carries the counts and read words that the requirements predict one edge later, and the bench compares the outputs against them. A write into a full FIFO and a read from an empty FIFO meet the same count logic. Directed steps drive these cases at the capacity and empty boundaries and check that the count holds and that the sticky flags rise.

// File: rtl/splitfifo_pkg.sv
package splitfifo_pkg;

  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic wrDo;
    logic rd0Do;
    logic rd1Do;
  } fifoStrb_t;

endpackage

// File: rtl/splitfifo_ctrl.sv
module splitfifo_ctrl
  import splitfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgDual,
  input  logic [CW-1:0] cfgThresh,
  input  logic          wrEn,
  input  logic          wrSel,
  input  logic [1:0]    rdEn,
  output fifoStrb_t     strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr0,
  output logic [AW-1:0] rdAddr1,
  output logic [CW-1:0] count0,
  output logic [CW-1:0] count1,
  output logic [1:0]    full,
  output logic [1:0]    empty,
  output logic [1:0]    dmaReq,
  output logic [1:0]    overflow,
  output logic [1:0]    underflow
);

  localparam int HALF = DEPTH / 2;

  logic          modeDual;
  logic [CW-1:0] threshReg;
  logic          idle;
  logic          flush;

  logic [1:0][CW-1:0] cntAll;
  logic [1:0][AW-1:0] wrPtrAll;
  logic [1:0][AW-1:0] rdPtrAll;
  logic [1:0]         wrOkAll;
  logic [1:0]         rdOkAll;

  assign idle  = (cntAll[0] == '0) && (cntAll[1] == '0) && !wrEn && (rdEn == 2'b00);
  assign flush = idle && (cfgDual != modeDual);

  // configuration capture, only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeDual  <= 1'b0;
      threshReg <= '0;
    end else if (idle) begin
      modeDual  <= cfgDual;
      threshReg <= cfgThresh;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_part
    localparam logic [AW-1:0] BASE = AW'(i * HALF);

    logic          active;
    logic [CW-1:0] cap;
    logic [AW-1:0] last;
    logic          wrHit, wrOk, rdOk, isFull, isEmpty;
    logic [AW-1:0] wrPtr, rdPtr;
    logic [CW-1:0] cnt;
    logic          ovf, udf;

    assign active  = (i == 0) || modeDual;
    assign cap     = modeDual ? CW'(HALF) : CW'(DEPTH);
    assign last    = (i == 0 && modeDual) ? AW'(HALF - 1) : AW'(DEPTH - 1);
    assign wrHit   = wrEn && active && (modeDual ? (wrSel == 1'(i)) : 1'b1);
    assign isFull  = active && (cnt == cap);
    assign isEmpty = (cnt == '0);
    assign wrOk    = wrHit && !isFull;
    assign rdOk    = rdEn[i] && active && !isEmpty;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= BASE;
        rdPtr <= BASE;
        cnt   <= '0;
        ovf   <= 1'b0;
        udf   <= 1'b0;
      end else if (flush) begin
        wrPtr <= BASE;
        rdPtr <= BASE;
        cnt   <= '0;
      end else begin
        if (wrOk) wrPtr <= (wrPtr == last) ? BASE : wrPtr + 1'b1;
        if (rdOk) rdPtr <= (rdPtr == last) ? BASE : rdPtr + 1'b1;
        cnt <= cnt + CW'(wrOk) - CW'(rdOk);
        if (wrHit && isFull) ovf <= 1'b1;
        if (rdEn[i] && active && isEmpty) udf <= 1'b1;
      end
    end

    assign cntAll[i]    = cnt;
    assign wrPtrAll[i]  = wrPtr;
    assign rdPtrAll[i]  = rdPtr;
    assign wrOkAll[i]   = wrOk;
    assign rdOkAll[i]   = rdOk;
    assign full[i]      = isFull;
    assign empty[i]     = isEmpty;
    assign dmaReq[i]    = active && (cnt < threshReg);
    assign overflow[i]  = ovf;
    assign underflow[i] = udf;
  end

  assign strb.wrDo  = |wrOkAll;
  assign strb.rd0Do = rdOkAll[0];
  assign strb.rd1Do = rdOkAll[1];
  assign wrAddr     = wrOkAll[1] ? wrPtrAll[1] : wrPtrAll[0];
  assign rdAddr0    = rdPtrAll[0];
  assign rdAddr1    = rdPtrAll[1];
  assign count0     = cntAll[0];
  assign count1     = cntAll[1];

endmodule

// File: rtl/splitfifo_dpath.sv
module splitfifo_dpath
  import splitfifo_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrb_t     strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  input  logic [AW-1:0] rdAddr0,
  input  logic [AW-1:0] rdAddr1,
  output logic [W-1:0]  rdData0,
  output logic [W-1:0]  rdData1
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrDo) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData0 <= '0;
      rdData1 <= '0;
    end else begin
      if (strb.rd0Do) rdData0 <= store[rdAddr0];
      if (strb.rd1Do) rdData1 <= store[rdAddr1];
    end
  end

endmodule

// File: rtl/splitfifo.sv
module splitfifo
  import splitfifo_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgDual,
  input  logic [CW-1:0] cfgThresh,
  input  logic          wrEn,
  input  logic          wrSel,
  input  logic [W-1:0]  wrData,
  input  logic [1:0]    rdEn,
  output logic [W-1:0]  rdData0,
  output logic [W-1:0]  rdData1,
  output logic [CW-1:0] count0,
  output logic [CW-1:0] count1,
  output logic [1:0]    full,
  output logic [1:0]    empty,
  output logic [1:0]    dmaReq,
  output logic [1:0]    overflow,
  output logic [1:0]    underflow
);

  localparam int AW = $clog2(DEPTH);

  fifoStrb_t     strb;
  logic [AW-1:0] wrAddr, rdAddr0, rdAddr1;

  splitfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgDual(cfgDual), .cfgThresh(cfgThresh),
    .wrEn(wrEn), .wrSel(wrSel), .rdEn(rdEn), .strb(strb),
    .wrAddr(wrAddr), .rdAddr0(rdAddr0), .rdAddr1(rdAddr1),
    .count0(count0), .count1(count1), .full(full), .empty(empty),
    .dmaReq(dmaReq), .overflow(overflow), .underflow(underflow)
  );

  splitfifo_dpath #(.W(W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr0(rdAddr0), .rdAddr1(rdAddr1), .rdData0(rdData0), .rdData1(rdData1)
  );

endmodule

// File: rtl/splitfifo_checker.sv
module splitfifo_checker #(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          wrSel,
  input logic [1:0]    rdEn,
  input logic [W-1:0]  rdData0,
  input logic [CW-1:0] count0,
  input logic [CW-1:0] count1,
  input logic [1:0]    full,
  input logic [1:0]    empty,
  input logic [1:0]    overflow,
  input logic [1:0]    underflow
);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (count0 <= CW'(DEPTH)) && (count1 <= CW'(DEPTH / 2))); // R2

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(full[0] && empty[0])); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    full[0] && wrEn && !wrSel && !rdEn[0] |=> $stable(count0) && overflow[0]); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow[0] |=> overflow[0]); // R5

  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    empty[0] && rdEn[0] |=> $stable(rdData0) && underflow[0]); // R6

  AST_SIM_RW_HALF1: assert property (@(posedge clk) disable iff (!rstN)
    !empty[1] && !full[1] && wrEn && wrSel && rdEn[1] |=> $stable(count1)); // R7

endmodule

bind splitfifo splitfifo_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .rdEn(rdEn),
  .rdData0(rdData0), .count0(count0), .count1(count1), .full(full),
  .empty(empty), .overflow(overflow), .underflow(underflow)
);

// File: tb/splitfifo_bench.sv
module splitfifo_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int DEPTH = 512;
  localparam int HALF = DEPTH / 2;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NVEC = 10;

  // {wr, sel, rd0, rd1, data[7:0], expCnt0[3:0], expCnt1[3:0], expRd0[7:0], expRd1[7:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 4'd1, 4'd0, 8'hA2, 8'hFF},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h21, 4'd1, 4'd1, 8'hA2, 8'hFF},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h12, 4'd2, 4'd1, 8'hA2, 8'hFF},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h22, 4'd1, 4'd2, 8'h11, 8'hFF},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 4'd0, 4'd1, 8'h12, 8'h21},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h13, 4'd1, 4'd0, 8'h12, 8'h22},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 4'd0, 4'd0, 8'h13, 8'h22},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h23, 4'd0, 4'd1, 8'h13, 8'h22},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h24, 4'd0, 4'd1, 8'h13, 8'h23},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 4'd0, 4'd0, 8'h13, 8'h24}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgDual = 1'b0;
  logic [CW-1:0] cfgThresh = '0;
  logic          wrEn = 1'b0;
  logic          wrSel = 1'b0;
  logic [W-1:0]  wrData = '0;
  logic [1:0]    rdEn = 2'b00;
  logic [W-1:0]  rdData0, rdData1;
  logic [CW-1:0] count0, count1;
  logic [1:0]    full, empty, dmaReq, overflow, underflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  splitfifo #(.W(W), .DEPTH(DEPTH)) u_splitfifo (
    .clk(clk), .rstN(rstN), .cfgDual(cfgDual), .cfgThresh(cfgThresh),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdEn(rdEn),
    .rdData0(rdData0), .rdData1(rdData1), .count0(count0), .count1(count1),
    .full(full), .empty(empty), .dmaReq(dmaReq), .overflow(overflow),
    .underflow(underflow)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doWrite(input logic sel, input logic [W-1:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] which);
    rdEn = which;
    tick();
    rdEn = 2'b00;
  endtask

  initial begin
    int bad;
    cfgDual = 1'b0;
    cfgThresh = CW'(10);
    repeat (3) tick();
    // R9 reset state
    check(count0 == 0 && count1 == 0, "R9 counts in reset", {count0, count1}, 0);
    check(empty == 2'b11 && full == 2'b00, "R9 empty/full in reset", {empty, full}, 4'b1100);
    check(dmaReq == 2'b00 && overflow == 2'b00 && underflow == 2'b00,
          "R9 req/flags in reset", {dmaReq, overflow, underflow}, 0);
    check(rdData0 == 0 && rdData1 == 0, "R9 read data in reset", {rdData0, rdData1}, 0);
    rstN = 1'b1;
    check(dmaReq == 2'b00, "R9 request after release", dmaReq, 0);
    tick();
    // first idle edge captured single mode, threshold 10
    check(dmaReq == 2'b01, "R3 single empty requests, half1 inactive", dmaReq, 2'b01);

    // R1 fill single FIFO, alternating the half-select
    for (int i = 0; i < DEPTH; i++) begin
      doWrite(i[0], W'(i));
      if (i == 8) check(count0 == 9 && dmaReq[0] == 1'b1, "R3 count 9 below threshold", {count0, dmaReq}, {10'd9, 2'b01});
      if (i == 9) check(count0 == 10 && dmaReq[0] == 1'b0, "R3 count 10 at threshold", {count0, dmaReq}, {10'd10, 2'b00});
    end
    check(count0 == CW'(DEPTH) && count1 == 0, "R1 single capacity", {count0, count1}, {10'(DEPTH), 10'd0});
    check(full == 2'b01, "R1 single full flag", full, 2'b01);
    doWrite(1'b0, 32'hDEAD);
    check(count0 == CW'(DEPTH) && overflow == 2'b01, "R5 drop on full", {count0, overflow}, {10'(DEPTH), 2'b01});
    doRead(2'b10);
    check(underflow == 2'b00 && count0 == CW'(DEPTH) && rdData1 == 0, "R1 half1 read ignored",
          {underflow, count0}, {2'b00, 10'(DEPTH)});
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      doRead(2'b01);
      if (rdData0 != W'(i)) bad++;
    end
    check(bad == 0, "R1 single order (mismatch count)", bad, 0);
    check(empty == 2'b11 && count0 == 0, "R1 single drained", {empty, count0}, {2'b11, 10'd0});

    // R4 config change while busy is ignored
    doWrite(1'b0, 32'hA0);
    doWrite(1'b0, 32'hA1);
    doWrite(1'b0, 32'hA2);
    cfgDual = 1'b1;
    cfgThresh = CW'(2);
    repeat (3) tick();
    check(dmaReq == 2'b01 && count1 == 0, "R4 busy keeps old config", {dmaReq, count1}, {2'b01, 10'd0});
    repeat (3) doRead(2'b01);
    check(rdData0 == 32'hA2, "R8 last read word", rdData0, 32'hA2);
    tick();
    check(dmaReq == 2'b11, "R4 idle captures dual, threshold 2", dmaReq, 2'b11);

    // R2 dual capacity on half 1
    for (int i = 0; i < HALF; i++) doWrite(1'b1, W'(i));
    check(count1 == CW'(HALF) && count0 == 0, "R2 half1 capacity", {count1, count0}, {10'(HALF), 10'd0});
    check(full == 2'b10 && dmaReq == 2'b01, "R2 half1 full, R3 requests", {full, dmaReq}, 4'b1001);
    doWrite(1'b1, 32'hBEEF);
    check(count1 == CW'(HALF) && overflow == 2'b11, "R5 drop on full half1", {count1, overflow}, {10'(HALF), 2'b11});
    bad = 0;
    for (int i = 0; i < HALF; i++) begin
      doRead(2'b10);
      if (rdData1 != W'(i)) bad++;
    end
    check(bad == 0, "R2 half1 order (mismatch count)", bad, 0);
    check(rdData0 == 32'hA2 && underflow == 2'b00, "R2 half0 untouched", {rdData0, underflow}, {32'hA2, 2'b00});

    // vector table: interleaved halves, simultaneous read and write (R2 R7 R8 R6)
    for (int v = 0; v < NVEC; v++) begin
      logic [35:0] e;
      e = VEC[v];
      wrEn = e[35]; wrSel = e[34]; rdEn = {e[32], e[33]}; wrData = W'(e[31:24]);
      tick();
      wrEn = 1'b0; rdEn = 2'b00;
      check(count0 == CW'(e[23:20]) && count1 == CW'(e[19:16]), $sformatf("R7 vector %0d counts", v),
            {count0, count1}, {CW'(e[23:20]), CW'(e[19:16])});
      check(rdData0 == W'(e[15:8]) && rdData1 == W'(e[7:0]), $sformatf("R8 vector %0d read data", v),
            {rdData0, rdData1}, {W'(e[15:8]), W'(e[7:0])});
    end
    check(underflow == 2'b11, "R6 sticky underflow both halves", underflow, 2'b11);
    check(overflow == 2'b11, "R5 overflow stays sticky", overflow, 2'b11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule